// File: doc/BRIEF.md
# Mode-Switched Serial Configuration Loader for a 16-Channel LED Sink

This block takes a three-wire serial stream (shift clock, serial data, latch) and a mode select. It writes one of two per-channel settings stores for a constant-current LED sink. With the mode input low, the block loads brightness words: sixteen 12-bit words from a 192-bit chain. With the mode input high, it loads current-trim words: sixteen 6-bit words from a 96-bit chain. The latch is level-sensitive. While it is high, the selected store follows the chain. While it is low, both stores keep their values.

After a brightness latch, the chain is refilled in parallel with a 192-bit status packet. The packet holds the per-channel open-LED flags, the over-temperature flag and the current-trim store. The packet leaves on the serial output while the next brightness frame shifts in. The serial output always taps the top bit of the active-length chain, so several loaders can be chained output to input.

The open flags and the thermal flag arrive as inputs. The shift clock is a level that is sampled on the system clock. One rising edge of the shift clock gives exactly one shift.

Top module: `ledcfg_serial_loader`

## Requirements
- R1: After reset, `sdo`, every bit of `gs_words` and every bit of `dc_words` are 0, and the chain holds all zeros.
- R2: With `mode`=0, each low-to-high change of `sck` shifts `sdi` into chain bit 0, and bits move toward bit 191. A latch then copies all 192 bits to `gs_words`. Channel n sits at bits [12n+11:12n], so channel 15's MSB is the first bit sent.
- R3: With `mode`=1, a latch copies chain bits [95:0] to `dc_words`, with channel n at bits [6n+5:6n], and leaves `gs_words` unchanged.
- R4: While `lat` is low, shifting never changes `gs_words` or `dc_words`.
- R5: When `lat` falls with `mode`=0 and no deferred update is pending, the chain is loaded with the status packet. The packet has open flags in bits 15:0, the thermal flag in bit 16, `dc_words` in bits 119:24, and zeros in all other bits. `sdo` presents bit 191 at once, and each later `sck` rise presents the next lower bit.
- R6: With `mode`=1, `sdo` is chain bit 95, so data shifted in appears on `sdo` 96 shifts later, MSB first.
- R7: The first brightness latch after a current-trim latch leaves `gs_words` unchanged. The next `sck` rise (its `sdi` ignored) copies the chain into `gs_words` and loads the status packet. Later brightness latches take effect at once.
- R8: `mode` may change only while `lat` is low. A change while `lat` is high is a protocol error. A legal mode change alters neither store nor the chain, and moves `sdo` to the tap of the new length.
- R9: Holding `sck` high for several system clocks produces a single shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Shift clock level, sampled on `clk` |
| sdi | input | 1 | Serial data in, MSB first |
| lat | input | 1 | Level-sensitive latch |
| mode | input | 1 | 0 selects brightness words, 1 selects current-trim words |
| open_flags | input | 16 | Per-channel open-LED flags for the status packet |
| thermal_flag | input | 1 | Over-temperature flag for the status packet |
| sdo | output | 1 | Serial data out, top of the active chain |
| gs_words | output | 192 | Sixteen 12-bit brightness words |
| dc_words | output | 96 | Sixteen 6-bit current-trim words |

## Verification
The hardest state to reach is the deferred brightness update. It needs a current-trim latch, then a legal switch back to brightness mode, a full 192-bit frame and a latch. Only then do the held store and the one extra shift that commits it become visible. The directed sequence walks this path once. The seeded random rounds then mix modes so that it recurs, sometimes with `sck` held high for several cycles. Every frame's shifted-out bits are compared with a bench model of the chain, so status packets and chained data are both checked bit by bit.

// File: rtl/ledcfg_pkg.sv
package ledcfg_pkg;

    // Selects which settings store the latch writes
    typedef enum logic {
        LC_MODE_GRAY = 1'b0,
        LC_MODE_CORR = 1'b1
    } lc_mode_e;

    // Bit position where the trim copy starts inside the status packet:
    // flags rounded up to a whole byte
    function automatic int unsigned status_trim_offset(input int unsigned channels);
        return ((channels + 1 + 7) / 8) * 8;
    endfunction

endpackage

// File: rtl/ledcfg_edge_det.sv
module ledcfg_edge_det #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = lvl_q & ~level;
        end else begin : g_rise
            assign pulse = level & ~lvl_q;
        end
    endgenerate
endmodule

// File: rtl/ledcfg_status_pack.sv
module ledcfg_status_pack #(
    parameter int CHANNELS = 16,
    parameter int DC_BITS  = 6,
    parameter int PKT_LEN  = 192
) (
    input  logic [CHANNELS-1:0]         open_flags,
    input  logic                        thermal_flag,
    input  logic [CHANNELS*DC_BITS-1:0] dc_words,
    output logic [PKT_LEN-1:0]          packet
);
    import ledcfg_pkg::*;

    localparam int DC_LEN = CHANNELS * DC_BITS;
    localparam int DC_OFS = int'(status_trim_offset(CHANNELS));

    always_comb begin
        packet                  = '0;
        packet[CHANNELS-1:0]    = open_flags;
        packet[CHANNELS]        = thermal_flag;
        packet[DC_OFS +: DC_LEN] = dc_words;
    end
endmodule

// File: rtl/ledcfg_serial_loader.sv
module ledcfg_serial_loader #(
    parameter int CHANNELS = 16,
    parameter int GS_BITS  = 12,
    parameter int DC_BITS  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sck,
    input  logic                         sdi,
    input  logic                         lat,
    input  logic                         mode,
    input  logic [CHANNELS-1:0]          open_flags,
    input  logic                         thermal_flag,
    output logic                         sdo,
    output logic [CHANNELS*GS_BITS-1:0]  gs_words,
    output logic [CHANNELS*DC_BITS-1:0]  dc_words
);
    import ledcfg_pkg::*;

    localparam int GS_LEN = CHANNELS * GS_BITS;
    localparam int DC_LEN = CHANNELS * DC_BITS;

    typedef struct packed {
        logic [GS_LEN-1:0] chain;        // one chain, tapped by mode
        logic [GS_LEN-1:0] gs;
        logic [DC_LEN-1:0] dc;
        logic              trim_since_gs; // trim latched since last brightness commit
        logic              gs_deferred;   // brightness commit waits for one shift
    } ld_state_t;

    ld_state_t st_d, st_q;
    lc_mode_e  mode_e;
    logic      sck_rise;
    logic      lat_fall;
    logic [GS_LEN-1:0] status_pkt;

    assign mode_e = lc_mode_e'(mode);

    ledcfg_edge_det #(.FALLING(1'b0)) u_sck_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sck),
        .pulse (sck_rise)
    );

    ledcfg_edge_det #(.FALLING(1'b1)) u_lat_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lat),
        .pulse (lat_fall)
    );

    ledcfg_status_pack #(
        .CHANNELS (CHANNELS),
        .DC_BITS  (DC_BITS),
        .PKT_LEN  (GS_LEN)
    ) u_status (
        .open_flags   (open_flags),
        .thermal_flag (thermal_flag),
        .dc_words     (st_q.dc),
        .packet       (status_pkt)
    );

    always_comb begin
        st_d = st_q;

        // Level-sensitive store update
        if (lat) begin
            if (mode_e == LC_MODE_CORR) begin
                st_d.dc            = st_q.chain[DC_LEN-1:0];
                st_d.trim_since_gs = 1'b1;
            end else if (!st_q.trim_since_gs) begin
                st_d.gs = st_q.chain;
            end
        end

        // Chain update: latch release has priority over a shift
        if (lat_fall && mode_e == LC_MODE_GRAY) begin
            if (st_q.trim_since_gs) st_d.gs_deferred = 1'b1;
            else                    st_d.chain       = status_pkt;
        end else if (sck_rise) begin
            if (st_q.gs_deferred) begin
                st_d.gs            = st_q.chain;
                st_d.chain         = status_pkt;
                st_d.gs_deferred   = 1'b0;
                st_d.trim_since_gs = 1'b0;
            end else begin
                st_d.chain = {st_q.chain[GS_LEN-2:0], sdi};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo      = (mode_e == LC_MODE_CORR) ? st_q.chain[DC_LEN-1] : st_q.chain[GS_LEN-1];
    assign gs_words = st_q.gs;
    assign dc_words = st_q.dc;

    // R8: mode is held steady while the latch stays high
    assert_mode_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat && $past(lat)) |-> $stable(mode));

    // R4: brightness store moves only under latch or the committing shift
    assert_gs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat && !sck_rise) |=> $stable(gs_words));

    // R4: trim store moves only under latch in trim mode
    assert_dc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat || mode_e == LC_MODE_GRAY) |=> $stable(dc_words));

    // R5: status packet replaces chain on an immediate brightness latch release
    assert_status_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_fall && mode_e == LC_MODE_GRAY && !st_q.trim_since_gs)
        |=> (st_q.chain == $past(status_pkt)));

    // R7: pending commit holds the brightness store through the latch
    assert_defer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat && mode_e == LC_MODE_GRAY && st_q.trim_since_gs) |=> $stable(gs_words));

    // R7: the committing shift clears both pending flags
    assert_defer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && !lat_fall && st_q.gs_deferred)
        |=> (!st_q.gs_deferred && !st_q.trim_since_gs));

    // R2: a plain shift brings the serial input into bit 0
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && !lat_fall && !st_q.gs_deferred) |=> (st_q.chain[0] == $past(sdi)));
endmodule

// File: tb/ledcfg_serial_loader_tb.sv
`timescale 1ns/1ps
module ledcfg_serial_loader_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         sdi = 1'b0;
    logic         lat = 1'b0;
    logic         mode = 1'b0;
    logic [15:0]  open_flags = '0;
    logic         thermal_flag = 1'b0;
    logic         sdo;
    logic [191:0] gs_words;
    logic [95:0]  dc_words;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [191:0] exp_chain = '0;
    logic [191:0] exp_gs = '0;
    logic [95:0]  exp_dc = '0;
    bit           exp_pend = 1'b0;

    always #2 clk = ~clk;

    ledcfg_serial_loader u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .lat(lat), .mode(mode),
        .open_flags(open_flags), .thermal_flag(thermal_flag),
        .sdo(sdo), .gs_words(gs_words), .dc_words(dc_words)
    );

    function automatic logic [191:0] status_of(input logic [15:0] o, input logic t,
                                               input logic [95:0] d);
        return {72'b0, d, 7'b0, t, o};
    endfunction

    function automatic logic [191:0] rand192();
        return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check_eq(input string tag, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic d, input int hold);
        @(negedge clk);
        sdi = d;
        sck = 1'b1;
        repeat (hold) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [191:0] v, input int len, input int hold,
                        output logic [191:0] got);
        got = '0;
        for (int i = len - 1; i >= 0; i--) begin
            got[i] = sdo;
            pulse(v[i], hold);
        end
    endtask

    task automatic latch_pulse();
        @(negedge clk); lat = 1'b1;
        @(negedge clk); lat = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
        check_eq("R8 store unchanged by mode switch", {gs_words}, exp_gs);
        check_eq("R8 sdo tap follows mode", {191'b0, sdo},
                 {191'b0, (m ? exp_chain[95] : exp_chain[191])});
    endtask

    task automatic do_load(input logic m, input logic [191:0] v, input int hold);
        logic [191:0] got;
        set_mode(m);
        if (m) begin
            xfer(v, 96, hold, got);
            check_eq("R6 chained trim data out", got, {96'b0, exp_chain[95:0]});
            exp_chain = {exp_chain[95:0], v[95:0]};
        end else begin
            xfer(v, 192, hold, got);
            check_eq("R5 status/chain readback", got, exp_chain);
            exp_chain = v;
        end
        check_eq("R4 brightness held while latch low", gs_words, exp_gs);
        check_eq("R4 trim held while latch low", {96'b0, dc_words}, {96'b0, exp_dc});
        latch_pulse();
        if (m) begin
            exp_dc = exp_chain[95:0];
            exp_pend = 1'b1;
            check_eq("R3 trim store", {96'b0, dc_words}, {96'b0, exp_dc});
            check_eq("R3 brightness untouched", gs_words, exp_gs);
        end else if (!exp_pend) begin
            exp_gs = exp_chain;
            exp_chain = status_of(open_flags, thermal_flag, exp_dc);
            check_eq("R2 brightness store", gs_words, exp_gs);
            check_eq("R5 sdo shows status MSB", {191'b0, sdo}, {191'b0, exp_chain[191]});
        end else begin
            check_eq("R7 brightness held at deferred latch", gs_words, exp_gs);
            check_eq("R7 chain kept until extra shift", {191'b0, sdo}, {191'b0, exp_chain[191]});
            pulse(1'b1, 1);
            exp_gs = exp_chain;
            exp_chain = status_of(open_flags, thermal_flag, exp_dc);
            exp_pend = 1'b0;
            @(negedge clk);
            check_eq("R7 extra shift commits brightness", gs_words, exp_gs);
        end
    endtask

    initial begin
        logic [191:0] v;
        void'($urandom(32'h5EED_0A17));
        repeat (4) @(negedge clk);
        // R1 reset state
        check_eq("R1 reset brightness", gs_words, '0);
        check_eq("R1 reset trim", {96'b0, dc_words}, '0);
        check_eq("R1 reset sdo", {191'b0, sdo}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: immediate brightness load, then status readback
        open_flags = 16'hA5C3; thermal_flag = 1'b1;
        do_load(1'b0, rand192(), 1);
        open_flags = 16'h0F0F; thermal_flag = 1'b0;
        do_load(1'b0, rand192(), 1);
        // Trim loads, second one reads the first back on sdo
        do_load(1'b1, rand192(), 1);
        do_load(1'b1, rand192(), 1);
        // First brightness load after trim: deferred commit
        open_flags = 16'h8001; thermal_flag = 1'b1;
        do_load(1'b0, rand192(), 1);
        do_load(1'b0, rand192(), 1);
        // R9: long sck high pulses
        v = rand192();
        do_load(1'b0, v, 3);
        check_eq("R9 one shift per sck rise", gs_words, v);
        // Corner words: all ones and all zeros
        do_load(1'b0, {192{1'b1}}, 1);
        do_load(1'b1, {192{1'b1}}, 2);
        do_load(1'b0, '0, 1);

        // Seeded random rounds
        for (int r = 0; r < 10; r++) begin
            open_flags   = 16'($urandom());
            thermal_flag = 1'($urandom_range(0, 1));
            do_load(1'($urandom_range(0, 1)), rand192(), int'($urandom_range(1, 2)));
        end
        set_mode(1'b0);
        do_load(1'b0, rand192(), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule